// File: doc/BRIEF.md
# Oversampling Serial Receiver with Ready-to-Send Output

This block receives asynchronous serial bytes on a single input line. A count source is taken either straight from the system clock or from the clock divided by eight. An 8-bit reload divider turns that source into a sample tick at sixteen times the bit rate. The receiver waits for a high-to-low edge on the synchronised line, confirms the start bit at its centre, shifts in eight data bits with the least significant bit first, and then samples one stop bit. The finished byte is copied into a holding register, and two separate flags are raised: a byte-ready flag and an interrupt request.

An active-low ready-to-send output tells the far end when a byte may be sent. It is low only while reception is enabled and the receiver is idle. Reading the holding register clears the byte-ready flag. Acknowledging the interrupt clears the interrupt request. Each flag leaves the other untouched. A low stop bit still stores the byte and also marks a framing error. Dropping the enable abandons any frame in progress.

Top module: `serial_rx_rts`

## Requirements
- R1: One bit period lasts 16*(div_val+1) count-source periods. The count source is the clock when src_div8=0 and one pulse every 8 clocks when src_div8=1. A frame's store happens about 9.5 bit periods after the start edge.
- R2: Reception begins only on a high-to-low transition of the synchronised line while rx_en=1. If the line reads high at the start bit's centre sample, the receiver returns to idle and sets no flag.
- R3: Eight data bits are sampled at bit centres with the first received bit placed in rx_data[0], followed by one stop bit; no parity bit exists.
- R4: When the stop bit is sampled, rx_data takes the received byte, and rx_done and rx_irq are both 1 in the next cycle. rx_data changes at no other time.
- R5: A pulse on irq_ack clears rx_irq and leaves rx_done unchanged. A pulse on buf_rd clears rx_done and leaves rx_irq unchanged. A new store takes priority over either clear.
- R6: frame_err shows the stop bit of the last stored byte: 1 when that stop bit sampled low, 0 when high. The byte is stored in both cases.
- R7: rts_n is low only while rx_en=1 and no frame is in progress. It goes high from the cycle after a start edge is detected until the byte is stored. It is high in the cycle after any cycle with rx_en=0.
- R8: Clearing rx_en abandons any frame in progress, and that frame sets no flag.
- R9: After reset, rx_data=0, rx_done=0, rx_irq=0, frame_err=0 and rts_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| div_val | input | 8 | Divider reload value n |
| src_div8 | input | 1 | Count source select: 0 = clock, 1 = clock/8 |
| rxd | input | 1 | Serial data input, idle high |
| irq_ack | input | 1 | Interrupt acknowledge / clear pulse |
| buf_rd | input | 1 | Holding-register read pulse |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | Byte-ready flag |
| rx_irq | output | 1 | Interrupt request |
| frame_err | output | 1 | Stop bit of last stored byte was low |
| rts_n | output | 1 | Active-low ready-to-send |

## Verification
On every cycle, the assertions check the following. rts_n stays high whenever a frame is in progress or the enable was low in the previous cycle. A disabled receiver never raises an interrupt. The two flags rise together. Each clear pulse affects only its own flag. The holding register moves only on a store. The bench scenarios are what show the actual bit rate under both count sources and the received bit order. They also show rejection of a short start glitch, framing-error reporting and recovery, and that an aborted frame leaves nothing behind.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W   = 8,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_div8,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0]    pre_cnt;
  logic             src_en;
  logic [DIV_W-1:0] div_cnt;

  // prescaler: free-running count of PRE_DIV clocks
  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else if (pre_cnt == PW'(PRE_DIV - 1)) pre_cnt <= '0;
    else pre_cnt <= pre_cnt + 1'b1;
  end

  assign src_en = src_div8 ? (pre_cnt == PW'(PRE_DIV - 1)) : 1'b1;

  // reload divider: one tick per underflow
  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (src_en) begin
        if (div_cnt == '0) begin
          div_cnt <= div_val;
          tick    <= 1'b1;
        end else begin
          div_cnt <= div_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 tick,
  input  logic                 rxd_s,
  output logic                 busy,
  output logic                 frm_end,
  output logic                 stop_bit,
  output logic [DATA_BITS-1:0] shreg,
  output logic                 rts_n
);
  localparam int TW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_BITS + 1);
  localparam int HALF = OVS / 2;

  rx_state_e            state, state_n;
  logic [TW-1:0]        tcnt, tcnt_n;
  logic [BW-1:0]        bcnt, bcnt_n;
  logic [DATA_BITS-1:0] sh_n;
  logic                 rxd_prev;

  always_comb begin
    state_n = state;
    tcnt_n  = tcnt;
    bcnt_n  = bcnt;
    sh_n    = shreg;
    frm_end = 1'b0;
    if (!en) begin
      state_n = RX_IDLE;
      tcnt_n  = '0;
      bcnt_n  = '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (rxd_prev && !rxd_s) begin
            state_n = RX_START;
            tcnt_n  = '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt == TW'(HALF - 1)) begin
              tcnt_n = '0;
              bcnt_n = '0;
              state_n = rxd_s ? RX_IDLE : RX_DATA;
            end else begin
              tcnt_n = tcnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (tcnt == TW'(OVS - 1)) begin
              tcnt_n = '0;
              sh_n   = {rxd_s, shreg[DATA_BITS-1:1]};
              if (bcnt == BW'(DATA_BITS - 1)) state_n = RX_STOP;
              else bcnt_n = bcnt + 1'b1;
            end else begin
              tcnt_n = tcnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (tcnt == TW'(OVS - 1)) begin
              tcnt_n  = '0;
              frm_end = 1'b1;
              state_n = RX_IDLE;
            end else begin
              tcnt_n = tcnt + 1'b1;
            end
          end
        end
        default: state_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      tcnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      rxd_prev <= 1'b1;
      rts_n    <= 1'b1;
    end else begin
      state    <= state_n;
      tcnt     <= tcnt_n;
      bcnt     <= bcnt_n;
      shreg    <= sh_n;
      rxd_prev <= rxd_s;
      rts_n    <= !(en && (state_n == RX_IDLE));
    end
  end

  assign busy     = (state != RX_IDLE);
  assign stop_bit = rxd_s;
endmodule

// File: rtl/serial_rx_rts.sv
module serial_rx_rts #(
  parameter int DIV_W       = 8,
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_en,
  input  logic [DIV_W-1:0]     div_val,
  input  logic                 src_div8,
  input  logic                 rxd,
  input  logic                 irq_ack,
  input  logic                 buf_rd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_done,
  output logic                 rx_irq,
  output logic                 frame_err,
  output logic                 rts_n
);
  logic                 tick;
  logic                 rxd_s;
  logic                 fsm_busy;
  logic                 frm_end;
  logic                 stop_bit;
  logic [DATA_BITS-1:0] shreg;

  rx_tick_gen #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_tick (
    .clk(clk), .rst(rst), .src_div8(src_div8), .div_val(div_val), .tick(tick)
  );

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
  );

  rx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_fsm (
    .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .rxd_s(rxd_s),
    .busy(fsm_busy), .frm_end(frm_end), .stop_bit(stop_bit),
    .shreg(shreg), .rts_n(rts_n)
  );

  // holding register and flags; a store wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_done   <= 1'b0;
      rx_irq    <= 1'b0;
      frame_err <= 1'b0;
    end else if (frm_end) begin
      rx_data   <= shreg;
      rx_done   <= 1'b1;
      rx_irq    <= 1'b1;
      frame_err <= !stop_bit;
    end else begin
      if (buf_rd)  rx_done <= 1'b0;
      if (irq_ack) rx_irq  <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_rts_chk.sv
module serial_rx_rts_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_en,
  input logic                 irq_ack,
  input logic                 buf_rd,
  input logic                 frm_end,
  input logic                 busy,
  input logic                 rx_irq,
  input logic                 rx_done,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rts_n
);
  p_disabled_rts_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> rts_n);

  p_busy_rts_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> rts_n);

  p_no_irq_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !$rose(rx_irq));

  p_flags_together_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> rx_irq);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !frm_end |=> $stable(rx_data));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !frm_end) |=> !rx_irq);

  p_rd_keeps_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (buf_rd && !irq_ack && rx_irq) |=> rx_irq);

  p_ack_keeps_done_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !buf_rd && rx_done) |=> rx_done);
endmodule

bind serial_rx_rts serial_rx_rts_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .irq_ack(irq_ack), .buf_rd(buf_rd),
  .frm_end(frm_end), .busy(fsm_busy), .rx_irq(rx_irq), .rx_done(rx_done),
  .rx_data(rx_data), .rts_n(rts_n)
);

// File: tb/tb_serial_rx_rts.sv
module tb_serial_rx_rts;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic [7:0] div_val = 8'd1;
  logic       src_div8 = 1'b0;
  logic       rxd = 1'b1;
  logic       irq_ack = 1'b0;
  logic       buf_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_done, rx_irq, frame_err, rts_n;

  int nchk = 0, nerr = 0;
  int cyc = 0;
  int tick_p = 2;        // clocks per sample tick
  int start_cyc = 0;
  logic [8:0] exp_q[$];  // {frame_err, data}
  logic irq_prev = 1'b0;

  serial_rx_rts dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .div_val(div_val), .src_div8(src_div8),
    .rxd(rxd), .irq_ack(irq_ack), .buf_rd(buf_rd), .rx_data(rx_data),
    .rx_done(rx_done), .rx_irq(rx_irq), .frame_err(frame_err), .rts_n(rts_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int bit_clks();
    return 16 * tick_p;
  endfunction

  // driver: sends a frame and pushes the expected result
  task automatic send_frame(input logic [7:0] b, input logic stop);
    exp_q.push_back({~stop, b});
    @(negedge clk);
    start_cyc = cyc;
    rxd = 1'b0;
    clks(bit_clks());
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      clks(bit_clks());
      if (i == 3) chk(rts_n == 1'b1, "R7 rts_n high mid-frame", rts_n, 1);
    end
    rxd = stop;
    clks(bit_clks());
    rxd = 1'b1;
  endtask

  task automatic service();
    clks(bit_clks());
    chk(rx_done == 1'b1, "R4 rx_done set", rx_done, 1);
    chk(rts_n == 1'b0, "R7 rts_n low after store", rts_n, 0);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(rx_irq == 1'b0, "R5 irq_ack clears rx_irq", rx_irq, 0);
    chk(rx_done == 1'b1, "R5 irq_ack keeps rx_done", rx_done, 1);
    buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
    chk(rx_done == 1'b0, "R5 buf_rd clears rx_done", rx_done, 0);
    chk(rx_irq == 1'b0, "R5 buf_rd keeps rx_irq low", rx_irq, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_irq && !irq_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected store", 1, 0);
        end else begin
          logic [8:0] e;
          int d;
          e = exp_q.pop_front();
          chk(rx_data == e[7:0], "R3 received byte", rx_data, e[7:0]);
          chk(frame_err == e[8], "R6 frame_err", frame_err, e[8]);
          chk(rx_done == 1'b1, "R4 rx_done with rx_irq", rx_done, 1);
          d = cyc - start_cyc;
          chk(d >= 151 * tick_p && d <= 153 * tick_p + 8, "R1 store timing", d, 152 * tick_p);
        end
      end
      irq_prev = rx_irq;
    end
  end

  initial begin
    clks(4);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(rx_data == 8'h00, "R9 rx_data reset", rx_data, 0);
    chk(rx_done == 1'b0, "R9 rx_done reset", rx_done, 0);
    chk(rx_irq == 1'b0, "R9 rx_irq reset", rx_irq, 0);
    chk(frame_err == 1'b0, "R9 frame_err reset", frame_err, 0);
    chk(rts_n == 1'b1, "R9 rts_n reset", rts_n, 1);

    div_val = 8'd1; src_div8 = 1'b0; tick_p = 2;
    rx_en = 1'b1;
    clks(3);
    chk(rts_n == 1'b0, "R7 rts_n low when enabled idle", rts_n, 0);

    send_frame(8'hA5, 1'b1); service();
    send_frame(8'h01, 1'b1); service();   // R3 first bit lands in bit 0
    send_frame(8'h80, 1'b1); service();

    // R2 short start glitch
    @(negedge clk); rxd = 1'b0;
    clks(4 * tick_p);
    rxd = 1'b1;
    clks(2 * bit_clks());
    chk(rx_irq == 1'b0, "R2 glitch sets no irq", rx_irq, 0);
    chk(rx_done == 1'b0, "R2 glitch sets no done", rx_done, 0);
    chk(rts_n == 1'b0, "R2 idle again after glitch", rts_n, 0);

    // R6 framing error then recovery
    send_frame(8'h3C, 1'b0); service();
    send_frame(8'h5A, 1'b1); service();

    // R8 abort by disabling mid-frame
    @(negedge clk); rxd = 1'b0;
    clks(3 * bit_clks());
    chk(rts_n == 1'b1, "R7 rts_n high during frame", rts_n, 1);
    rx_en = 1'b0;
    clks(2);
    chk(rts_n == 1'b1, "R7 rts_n high when disabled", rts_n, 1);
    clks(4 * bit_clks());
    rxd = 1'b1;
    clks(8 * bit_clks());
    chk(rx_irq == 1'b0, "R8 aborted frame sets no irq", rx_irq, 0);
    chk(rx_done == 1'b0, "R8 aborted frame sets no done", rx_done, 0);
    rx_en = 1'b1;
    clks(3);
    chk(rts_n == 1'b0, "R7 rts_n low after re-enable", rts_n, 0);
    send_frame(8'h69, 1'b1); service();

    // R1 other rates: clock/8 source, and a larger divider
    src_div8 = 1'b1; div_val = 8'd1; tick_p = 16;
    clks(64);
    send_frame(8'hC3, 1'b1); service();
    src_div8 = 1'b0; div_val = 8'd3; tick_p = 4;
    clks(16);
    send_frame(8'h96, 1'b1); service();

    chk(exp_q.size() == 0, "R4 all frames stored", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule